// File: doc/BRIEF.md
# Port-to-Pin Bit Mapper

This block sits between a set of numbered integer data ports and a wide bank of tester pins. A small table of mapping records says where each port's bits go. A drive record scatters bits of an input-port value onto a contiguous run of pins. A sense record gathers a contiguous run of pins into bits of an output-port value. A constant record ties a run of pins to a fixed level. Ports have no names. A port is selected by its number.

A port may use several records. The records are taken in ascending table index. The lowest-indexed record for a port supplies that port's least significant bits, and each later record continues upward. On an apply strobe every pin takes its new level in the same cycle. On a capture strobe every output port latches at once. Each output port is read back either zero-extended or sign-extended from its total mapped width to 32 bits.

Top module: `pin_mapper`

## Requirements
- R1: While reset is asserted and in the cycle after it, `pins_out` is all zero, `out_flat` is all zero, `conflict` is low, and every table record is off.
- R2: Record kinds are encoded on `rec_kind` as 0 = off, 1 = drive, 2 = sense, 3 = constant. The clock edge that samples `apply` high loads every pin at once. For a drive record, pin `start+k` takes bit `off+k` of the register value of that port as held before that edge. Here `off` is the summed length of the lower-indexed records of the same kind and port.
- R3: When a port has several records, its bits are filled from the LSB upward in ascending record index.
- R4: Every pin covered by a constant record is driven at that record's level after `apply`.
- R5: The clock edge that samples `capture` high latches every output port into `out_flat`. Port p occupies bits `[32p+31:32p]`. With its sign flag clear, a port's value is the gathered bits zero-extended.
- R6: With its sign flag set, a port's gathered value is sign-extended from its total sense width, meaning the summed length of its sense records. A width of 32 or more is not extended.
- R7: `conflict` is high exactly while some pin is covered by two or more active records. Such a pin is owned by the lowest-indexed record that covers it, and the later records are ignored there.
- R8: Pins covered by no record, and pins covered by sense records, are driven low. `pins_out` changes only on `apply`.
- R9: Bits that would land at position 32 or above in a port are dropped. For a drive record this leaves the pin low, and for a sense record the pin is not gathered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rec_we | input | 1 | Write one mapping record |
| rec_idx | input | 4 | Record slot, which is also its fill order |
| rec_kind | input | 2 | 0 off, 1 drive, 2 sense, 3 constant |
| rec_port | input | 2 | Port number the record belongs to |
| rec_start | input | 8 | First pin of the run |
| rec_len | input | 6 | Number of pins in the run |
| rec_level | input | 1 | Level for constant records |
| val_we | input | 1 | Write an input-port value register |
| val_port | input | 2 | Input port number |
| val_data | input | 32 | Input port value |
| sgn_we | input | 1 | Write an output-port sign flag |
| sgn_port | input | 2 | Output port number |
| sgn_val | input | 1 | 1 = two's-complement readback |
| apply | input | 1 | Update all pins from the table |
| capture | input | 1 | Latch all output ports |
| pins_in | input | 160 | Levels sensed on the pin bank |
| pins_out | output | 160 | Levels driven onto the pin bank |
| out_flat | output | 128 | Latched output ports, port p at bits 32p+31:32p |
| conflict | output | 1 | Some pin is claimed more than once |

## Verification
The bench builds the block with its defaults: 160 pins, four ports of each direction, sixteen record slots and 32-bit values. With these values, randomly placed runs reach the last pin and slot 15. Runs of up to 12 pins across six records per trial make several-record ports, ports wider than 32 bits and overlapping claims common. A directed 40-pin run exercises the drop above bit 31, and a 5-bit signed port exercises the extension.

// File: rtl/pin_mapper.sv
`timescale 1ns/1ps
module pin_mapper #(
  parameter int NUM_PINS  = 160,
  parameter int NUM_PORTS = 4,
  parameter int NUM_RECS  = 16,
  parameter int PORT_W    = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rec_we,
  input  logic [$clog2(NUM_RECS)-1:0]   rec_idx,
  input  logic [1:0]                    rec_kind,
  input  logic [$clog2(NUM_PORTS)-1:0]  rec_port,
  input  logic [$clog2(NUM_PINS)-1:0]   rec_start,
  input  logic [$clog2(PORT_W):0]       rec_len,
  input  logic                          rec_level,
  input  logic                          val_we,
  input  logic [$clog2(NUM_PORTS)-1:0]  val_port,
  input  logic [PORT_W-1:0]             val_data,
  input  logic                          sgn_we,
  input  logic [$clog2(NUM_PORTS)-1:0]  sgn_port,
  input  logic                          sgn_val,
  input  logic                          apply,
  input  logic                          capture,
  input  logic [NUM_PINS-1:0]           pins_in,
  output logic [NUM_PINS-1:0]           pins_out,
  output logic [NUM_PORTS*PORT_W-1:0]   out_flat,
  output logic                          conflict
);
  localparam int REC_W = $clog2(NUM_RECS);
  localparam int PRT_W = $clog2(NUM_PORTS);
  localparam int PIN_W = $clog2(NUM_PINS);
  localparam int LEN_W = $clog2(PORT_W) + 1;
  localparam int BIT_W = $clog2(PORT_W);
  localparam int OFF_W = LEN_W + REC_W;
  localparam logic [1:0] K_OFF = 2'd0, K_DRV = 2'd1, K_SNS = 2'd2, K_CON = 2'd3;

  logic [1:0]       kind_q  [NUM_RECS];
  logic [PRT_W-1:0] port_q  [NUM_RECS];
  logic [PIN_W-1:0] start_q [NUM_RECS];
  logic [LEN_W-1:0] len_q   [NUM_RECS];
  logic             lvl_q   [NUM_RECS];
  logic [PORT_W-1:0] val_q  [NUM_PORTS];
  logic [PORT_W-1:0] out_q  [NUM_PORTS];
  logic [NUM_PORTS-1:0] sgn_q;
  logic [NUM_PINS-1:0]  pins_q;

  logic [OFF_W-1:0]  off  [NUM_RECS];
  logic [OFF_W-1:0]  wid  [NUM_PORTS];
  logic [PORT_W-1:0] gath [NUM_PORTS];
  logic [PORT_W-1:0] ext  [NUM_PORTS];
  logic [NUM_PINS-1:0] nxt, clash;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int r = 0; r < NUM_RECS; r++) begin
        kind_q[r]  <= K_OFF;
        port_q[r]  <= '0;
        start_q[r] <= '0;
        len_q[r]   <= '0;
        lvl_q[r]   <= 1'b0;
      end
    end else if (rec_we) begin
      kind_q[rec_idx]  <= rec_kind;
      port_q[rec_idx]  <= rec_port;
      start_q[rec_idx] <= rec_start;
      len_q[rec_idx]   <= rec_len;
      lvl_q[rec_idx]   <= rec_level;
    end
  end

  always_comb begin
    for (int r = 0; r < NUM_RECS; r++) begin
      off[r] = '0;
      for (int q = 0; q < NUM_RECS; q++)
        if (q < r && kind_q[q] == kind_q[r] && port_q[q] == port_q[r])
          off[r] = off[r] + OFF_W'(len_q[q]);
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      wid[p] = '0;
      for (int q = 0; q < NUM_RECS; q++)
        if (kind_q[q] == K_SNS && port_q[q] == PRT_W'(p))
          wid[p] = wid[p] + OFF_W'(len_q[q]);
    end
  end

  always_comb begin
    nxt   = '0;
    clash = '0;
    for (int p = 0; p < NUM_PORTS; p++) gath[p] = '0;
    for (int i = 0; i < NUM_PINS; i++) begin
      logic             hit;
      logic [REC_W-1:0] own;
      int               rel;
      hit = 1'b0;
      own = '0;
      for (int r = 0; r < NUM_RECS; r++)
        if (kind_q[r] != K_OFF && i >= int'(start_q[r]) &&
            i < int'(start_q[r]) + int'(len_q[r])) begin
          if (hit) clash[i] = 1'b1;
          else begin
            hit = 1'b1;
            own = REC_W'(r);
          end
        end
      rel = int'(off[own]) + i - int'(start_q[own]);
      if (hit) begin
        case (kind_q[own])
          K_DRV: if (rel < PORT_W) nxt[i] = val_q[port_q[own]][rel[BIT_W-1:0]];
          K_SNS: if (rel < PORT_W) gath[port_q[own]][rel[BIT_W-1:0]] = pins_in[i];
          K_CON: nxt[i] = lvl_q[own];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      logic [PORT_W-1:0] mask;
      logic              top;
      mask = '0;
      top  = 1'b0;
      for (int b = 0; b < PORT_W; b++) begin
        if (b < int'(wid[p])) mask[b] = 1'b1;
        if (b == int'(wid[p]) - 1) top = gath[p][b];
      end
      ext[p] = gath[p] & mask;
      if (sgn_q[p] && top) ext[p] = ext[p] | ~mask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pins_q <= '0;
      sgn_q  <= '0;
      for (int p = 0; p < NUM_PORTS; p++) begin
        val_q[p] <= '0;
        out_q[p] <= '0;
      end
    end else begin
      if (val_we) val_q[val_port] <= val_data;
      if (sgn_we) sgn_q[sgn_port] <= sgn_val;
      if (apply)  pins_q <= nxt;
      if (capture)
        for (int p = 0; p < NUM_PORTS; p++) out_q[p] <= ext[p];
    end
  end

  assign pins_out = pins_q;
  assign conflict = |clash;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_out
    assign out_flat[p*PORT_W +: PORT_W] = out_q[p];
  end
endmodule

module pin_mapper_chk #(
  parameter int NUM_PINS  = 160,
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rec_we,
  input logic                        apply,
  input logic                        capture,
  input logic [NUM_PINS-1:0]         pins_out,
  input logic [NUM_PORTS*PORT_W-1:0] out_flat,
  input logic                        conflict
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (pins_out == '0 && out_flat == '0 && !conflict));

  // R8
  pins_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(pins_out));

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> $stable(out_flat));

  // R7
  conflict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_we |=> $stable(conflict));
endmodule

bind pin_mapper pin_mapper_chk #(
  .NUM_PINS(NUM_PINS), .NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rec_we(rec_we), .apply(apply),
  .capture(capture), .pins_out(pins_out), .out_flat(out_flat),
  .conflict(conflict)
);

// File: tb/pin_mapper_test.sv
`timescale 1ns/1ps
module pin_mapper_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         rec_we = 1'b0;
  logic [3:0]   rec_idx = '0;
  logic [1:0]   rec_kind = '0;
  logic [1:0]   rec_port = '0;
  logic [7:0]   rec_start = '0;
  logic [5:0]   rec_len = '0;
  logic         rec_level = 1'b0;
  logic         val_we = 1'b0;
  logic [1:0]   val_port = '0;
  logic [31:0]  val_data = '0;
  logic         sgn_we = 1'b0;
  logic [1:0]   sgn_port = '0;
  logic         sgn_val = 1'b0;
  logic         apply = 1'b0;
  logic         capture = 1'b0;
  logic [159:0] pins_in = '0;
  logic [159:0] pins_out;
  logic [127:0] out_flat;
  logic         conflict;

  int tests = 0;
  int fails = 0;

  int k_m [16];
  int p_m [16];
  int s_m [16];
  int l_m [16];
  int lv_m [16];
  logic [31:0] v_m [4];
  logic        sg_m [4];

  always #2.5 clk = ~clk;

  pin_mapper uut (.*);

  task automatic check(string req, logic [159:0] act, logic [159:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int moff(int r);
    int s = 0;
    for (int q = 0; q < r; q++)
      if (k_m[q] == k_m[r] && p_m[q] == p_m[r]) s += l_m[q];
    return s;
  endfunction

  function automatic int mown(int pin);
    for (int r = 0; r < 16; r++)
      if (k_m[r] != 0 && pin >= s_m[r] && pin < s_m[r] + l_m[r]) return r;
    return -1;
  endfunction

  function automatic logic mclash();
    for (int pin = 0; pin < 160; pin++) begin
      int n = 0;
      for (int r = 0; r < 16; r++)
        if (k_m[r] != 0 && pin >= s_m[r] && pin < s_m[r] + l_m[r]) n++;
      if (n > 1) return 1'b1;
    end
    return 1'b0;
  endfunction

  function automatic logic [159:0] exp_pins();
    logic [159:0] e = '0;
    for (int pin = 0; pin < 160; pin++) begin
      int r = mown(pin);
      if (r >= 0) begin
        int rel = moff(r) + pin - s_m[r];
        if (k_m[r] == 1 && rel < 32) e[pin] = v_m[p_m[r]][rel];
        if (k_m[r] == 3) e[pin] = lv_m[r][0];
      end
    end
    return e;
  endfunction

  function automatic logic [31:0] exp_out(int p);
    logic [31:0] g = '0;
    int w = 0;
    for (int r = 0; r < 16; r++) if (k_m[r] == 2 && p_m[r] == p) w += l_m[r];
    for (int pin = 0; pin < 160; pin++) begin
      int r = mown(pin);
      if (r >= 0 && k_m[r] == 2 && p_m[r] == p) begin
        int rel = moff(r) + pin - s_m[r];
        if (rel < 32) g[rel] = pins_in[pin];
      end
    end
    if (sg_m[p] && w > 0 && w < 32 && g[w-1])
      for (int b = w; b < 32; b++) g[b] = 1'b1;
    return g;
  endfunction

  task automatic wr_rec(int i, int k, int p, int s, int l, int lv);
    @(negedge clk);
    rec_we = 1'b1; rec_idx = 4'(i); rec_kind = 2'(k); rec_port = 2'(p);
    rec_start = 8'(s); rec_len = 6'(l); rec_level = lv[0];
    @(negedge clk);
    rec_we = 1'b0;
    k_m[i] = k; p_m[i] = p; s_m[i] = s; l_m[i] = l; lv_m[i] = lv;
  endtask

  task automatic clear_tab();
    for (int i = 0; i < 16; i++) wr_rec(i, 0, 0, 0, 0, 0);
  endtask

  task automatic wr_val(int p, logic [31:0] d);
    @(negedge clk);
    val_we = 1'b1; val_port = 2'(p); val_data = d;
    @(negedge clk);
    val_we = 1'b0;
    v_m[p] = d;
  endtask

  task automatic wr_sgn(int p, logic s);
    @(negedge clk);
    sgn_we = 1'b1; sgn_port = 2'(p); sgn_val = s;
    @(negedge clk);
    sgn_we = 1'b0;
    sg_m[p] = s;
  endtask

  task automatic do_apply();
    @(negedge clk); apply = 1'b1;
    @(negedge clk); apply = 1'b0;
  endtask

  task automatic do_capture();
    @(negedge clk); capture = 1'b1;
    @(negedge clk); capture = 1'b0;
  endtask

  task automatic check_outs(string req);
    for (int p = 0; p < 4; p++)
      check(req, 160'(out_flat[p*32 +: 32]), 160'(exp_out(p)));
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 16; i++) begin k_m[i] = 0; p_m[i] = 0; s_m[i] = 0; l_m[i] = 0; lv_m[i] = 0; end
    for (int p = 0; p < 4; p++) begin v_m[p] = '0; sg_m[p] = 1'b0; end
    repeat (4) @(negedge clk);
    check("R1", pins_out, '0);
    check("R1", 160'(out_flat), '0);
    check("R1", 160'(conflict), '0);
    rst_n = 1'b1;

    // R3: two records of port 0, low bits first
    wr_rec(0, 1, 0, 10, 4, 0);
    wr_rec(1, 1, 0, 100, 4, 0);
    wr_val(0, 32'h0000_00A5);
    do_apply();
    check("R3", 160'(pins_out[13:10]), 160'(4'h5));
    check("R3", 160'(pins_out[103:100]), 160'(4'hA));
    check("R2", pins_out, exp_pins());

    // R8: value change without apply leaves pins
    wr_val(0, 32'h0000_005A);
    @(negedge clk);
    check("R8", 160'(pins_out[13:10]), 160'(4'h5));

    // R6 / R5: 5-bit sense port, signed then unsigned
    clear_tab();
    wr_rec(2, 2, 1, 20, 5, 0);
    wr_sgn(1, 1'b1);
    pins_in = '0;
    pins_in[24:20] = 5'b10011;
    do_capture();
    check("R6", 160'(out_flat[63:32]), 160'(32'hFFFF_FFF3));
    wr_sgn(1, 1'b0);
    do_capture();
    check("R5", 160'(out_flat[63:32]), 160'(32'h0000_0013));

    // R4 / R7: constant run overlapped by a later drive run
    clear_tab();
    wr_val(2, 32'h0);
    wr_rec(0, 3, 0, 50, 4, 1);
    wr_rec(1, 1, 2, 52, 4, 0);
    do_apply();
    check("R4", 160'(pins_out[53:50]), 160'(4'hF));
    check("R7", 160'(conflict), 160'(1'b1));
    check("R8", 160'(pins_out[49:0]), '0);

    // R9: 40-pin drive run keeps only 32 bits
    clear_tab();
    check("R7", 160'(conflict), 160'(1'b0));
    wr_rec(15, 1, 3, 120, 40, 0);
    wr_val(3, 32'hFFFF_FFFF);
    do_apply();
    check("R9", 160'(pins_out[159:120]), 160'(40'h00_FFFF_FFFF));

    // random trials
    for (int t = 0; t < 40; t++) begin
      clear_tab();
      for (int j = 0; j < 6; j++)
        wr_rec((j == 5) ? 15 : j, 1 + int'($urandom_range(2)), int'($urandom_range(3)),
               int'($urandom_range(159)), 1 + int'($urandom_range(11)), int'($urandom_range(1)));
      for (int p = 0; p < 4; p++) begin
        wr_val(p, $urandom);
        wr_sgn(p, 1'($urandom_range(1)));
      end
      @(negedge clk);
      check("R7", 160'(conflict), 160'(mclash()));
      do_apply();
      check("R2", pins_out, exp_pins());
      pins_in = {$urandom, $urandom, $urandom, $urandom, $urandom};
      do_capture();
      check_outs("R5/R6");
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule